// File: doc/BRIEF.md
# Composite-Field AES Byte Substitution Unit

This block performs the AES byte substitution in either direction without a 256-entry lookup table. It is purely combinational. A byte enters on `din`, and `inv_mode` selects the direction. The substituted byte appears on `dout` in the same cycle.

The core of the unit is the multiplicative inverse in GF(2^8), with the zero byte sent to zero. To compute it, the byte is moved by a linear change of basis into the composite field GF((2^4)^2). There each element is a pair written b·x + c, with b and c taken from GF(2^4). The nibble field is reduced by x^4 + x + 1. The pair field is reduced by x^2 + x + λ, where λ is the first nibble that makes this quadratic irreducible.

In the composite field the inverse of b·x + c is built from the nibble norm Δ = b²λ + bc + c². The only nibble inversion needed is Δ⁻¹, and the result is (bΔ⁻¹)·x + (b+c)Δ⁻¹. The pair is then mapped back to the standard byte basis. Both basis matrices are derived at elaboration from a root of the AES polynomial found in the composite field. The forward direction applies the affine transform with constant 63h after the inversion. The inverse direction applies the inverse affine transform with constant 05h before the inversion.

Top module: `cf_sbox`

## Requirements
- R1: With `inv_mode` = 0, `dout` equals the standard AES forward S-box value of `din` for all 256 inputs (for example 01h gives 7Ch, 53h gives EDh, FFh gives 16h).
- R2: With `inv_mode` = 1, `dout` equals the standard AES inverse S-box value of `din` for all 256 inputs (for example 00h gives 52h, EDh gives 53h).
- R3: With `inv_mode` = 0 and `din` = 00h, `dout` is 63h, because zero is sent to zero by the inversion step.
- R4: With `inv_mode` = 1 and `din` = 63h, `dout` is 00h.
- R5: With `inv_mode` = 0 and `din` ≠ 00h, the inverse affine transform of `dout` multiplied by `din` equals 01h. The product is taken in GF(2^8) modulo 11Bh. The inverse affine is y_i = x_(i+2) ^ x_(i+5) ^ x_(i+7) ^ 05h_i, with indices taken mod 8.
- R6: With `inv_mode` = 1 and `din` ≠ 63h, `dout` multiplied by the inverse affine transform of `din` equals 01h in GF(2^8) modulo 11Bh.
- R7: Feeding the forward output of any byte back in with `inv_mode` = 1 returns the original byte, for all 256 bytes.
- R8: `dout` follows `din` and `inv_mode` with no clock, and settles within the same cycle as the input change.
- R9: In each mode the 256 inputs produce 256 distinct outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Byte to substitute |
| inv_mode | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| dout | output | 8 | Substituted byte |

## Verification
A wrong isomorphism matrix, λ, or nibble inverter almost never corrupts every byte. It shows up as a scattered subset of wrong outputs. The bench therefore sweeps all 256 inputs in both directions and checks distinctness in each direction; a broken basis matrix usually also collapses distinct inputs onto one output. Because the unit has no state, any such error is visible on `dout` in the very cycle the offending byte is applied. The internal inverse-times-input product is checked on every evaluation, so a faulty inverter is reported before it reaches the affine stage.

// File: rtl/sbox_cf_pkg.sv
// sbox_cf_pkg: shared widths, types and elaboration-time field arithmetic
// for the composite-field substitution unit.
// Assumes: byte width is twice the nibble width, nibble field reduced by x^4+x+1.
package sbox_cf_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int PROD_W = 2 * NIB_W - 1;
    localparam int N_BYTE = 1 << BYTE_W;
    localparam int N_NIB  = 1 << NIB_W;

    localparam logic [NIB_W:0]    NIB_POLY  = 5'b10011;     // x^4 + x + 1
    localparam logic [BYTE_W:0]   AES_POLY  = 9'h11B;       // x^8+x^4+x^3+x+1
    localparam logic [BYTE_W-1:0] FWD_AFF_C = 8'h63;
    localparam logic [BYTE_W-1:0] INV_AFF_C = 8'h05;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef struct packed {
        nib_t hi;   // coefficient b of x
        nib_t lo;   // constant coefficient c
    } cf_t;
    typedef logic [BYTE_W-1:0][BYTE_W-1:0] mat_t;  // mat[i] = image of basis bit i

    // Nibble multiply with reduction by NIB_POLY.
    function automatic nib_t gf4_mul(nib_t a, nib_t b);
        logic [PROD_W-1:0] p;
        p = '0;
        for (int i = 0; i < NIB_W; i++)
            if (b[i]) p ^= PROD_W'(a) << i;
        for (int k = PROD_W - 1; k >= NIB_W; k--)
            if (p[k]) p ^= PROD_W'(NIB_POLY) << (k - NIB_W);
        return p[NIB_W-1:0];
    endfunction

    function automatic nib_t gf4_sq(nib_t a);
        return gf4_mul(a, a);
    endfunction

    // Nibble inverse as a^(2^n - 2); zero maps to zero.
    function automatic nib_t gf4_inv(nib_t a);
        nib_t r;
        nib_t s;
        r = nib_t'(1);
        s = a;
        for (int k = 1; k < NIB_W; k++) begin
            s = gf4_sq(s);
            r = gf4_mul(r, s);
        end
        return r;
    endfunction

    // First lambda for which x^2 + x + lambda has no root in the nibble field.
    function automatic nib_t find_lambda();
        for (int l = 1; l < N_NIB; l++) begin
            logic has_root;
            has_root = 1'b0;
            for (int z = 0; z < N_NIB; z++)
                if ((gf4_sq(nib_t'(z)) ^ nib_t'(z) ^ nib_t'(l)) == '0) has_root = 1'b1;
            if (!has_root) return nib_t'(l);
        end
        return '0;
    endfunction

    localparam nib_t LAMBDA = find_lambda();

    // Composite multiply, x^2 = x + lambda.
    function automatic cf_t cf_mul(cf_t a, cf_t b);
        cf_t  r;
        nib_t hh;
        hh   = gf4_mul(a.hi, b.hi);
        r.hi = hh ^ gf4_mul(a.hi, b.lo) ^ gf4_mul(a.lo, b.hi);
        r.lo = gf4_mul(hh, LAMBDA) ^ gf4_mul(a.lo, b.lo);
        return r;
    endfunction

    // A root of the AES reduction polynomial inside the composite field.
    function automatic cf_t find_beta();
        for (int v = 2; v < N_BYTE; v++) begin
            cf_t cand;
            cf_t pw;
            cf_t acc;
            cand = cf_t'(byte_t'(v));
            pw   = cf_t'(byte_t'(1));
            acc  = '0;
            for (int k = 0; k <= BYTE_W; k++) begin
                if (AES_POLY[k]) acc ^= pw;
                pw = cf_mul(pw, cand);
            end
            if (acc == '0) return cand;
        end
        return '0;
    endfunction

    localparam cf_t BETA = find_beta();

    function automatic byte_t mat_apply(mat_t m, byte_t a);
        byte_t r;
        r = '0;
        for (int i = 0; i < BYTE_W; i++)
            if (a[i]) r ^= m[i];
        return r;
    endfunction

    // Standard basis to composite basis: bit i maps to BETA^i.
    function automatic mat_t build_iso();
        mat_t m;
        cf_t  pw;
        pw = cf_t'(byte_t'(1));
        for (int i = 0; i < BYTE_W; i++) begin
            m[i] = byte_t'(pw);
            pw   = cf_mul(pw, BETA);
        end
        return m;
    endfunction

    localparam mat_t ISO_MAT = build_iso();

    // Composite basis back to standard basis, found by preimage search.
    function automatic mat_t build_uniso();
        mat_t m;
        m = '0;
        for (int j = 0; j < BYTE_W; j++)
            for (int v = 0; v < N_BYTE; v++)
                if (mat_apply(ISO_MAT, byte_t'(v)) == (byte_t'(1) << j)) m[j] = byte_t'(v);
        return m;
    endfunction

    localparam mat_t UNISO_MAT = build_uniso();

    // Input bits that feed output bit j of a matrix.
    function automatic byte_t mat_select(mat_t m, int j);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) r[i] = m[i][j];
        return r;
    endfunction

endpackage

// File: rtl/sbox_cf_gf4_mul.sv
// sbox_cf_gf4_mul: nibble-field multiplier, x^4 + x + 1 reduction.
// Assumes: purely combinational, no operand ordering constraints.
module sbox_cf_gf4_mul
    import sbox_cf_pkg::*;
(
    input  nib_t a,
    input  nib_t b,
    output nib_t p
);
    // product of the two nibbles
    assign p = gf4_mul(a, b);
endmodule

// File: rtl/sbox_cf_gf4_sq.sv
// sbox_cf_gf4_sq: nibble-field squarer (linear in the bits).
// Assumes: purely combinational.
module sbox_cf_gf4_sq
    import sbox_cf_pkg::*;
(
    input  nib_t a,
    output nib_t q
);
    // square of the nibble
    assign q = gf4_sq(a);
endmodule

// File: rtl/sbox_cf_gf4_inv.sv
// sbox_cf_gf4_inv: nibble-field inverter, 16-entry table computed at elaboration.
// Assumes: zero input yields zero output.
module sbox_cf_gf4_inv
    import sbox_cf_pkg::*;
(
    input  nib_t a,
    output nib_t q
);
    nib_t inv_tab [N_NIB];

    // one table entry per nibble value
    for (genvar v = 0; v < N_NIB; v++) begin : g_ent
        assign inv_tab[v] = gf4_inv(nib_t'(v));
    end

    // table read
    assign q = inv_tab[a];
endmodule

// File: rtl/sbox_cf_basis_map.sv
// sbox_cf_basis_map: constant GF(2) matrix between the standard byte basis
// and the composite-field basis. TO_COMPOSITE picks the direction.
// Assumes: matrices derived in the package are mutually inverse.
module sbox_cf_basis_map
    import sbox_cf_pkg::*;
#(
    parameter bit TO_COMPOSITE = 1'b1
) (
    input  byte_t a,
    output byte_t q
);
    localparam mat_t M = TO_COMPOSITE ? ISO_MAT : UNISO_MAT;

    // each output bit is the parity of its selected input bits
    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
        localparam byte_t SEL = mat_select(M, j);
        assign q[j] = ^(a & SEL);
    end
endmodule

// File: rtl/sbox_cf_inverter.sv
// sbox_cf_inverter: inverse of b*x + c in GF((2^4)^2) via the nibble norm
// delta = b^2*lambda + b*c + c^2; result (b/delta)x + (b+c)/delta.
// Assumes: zero element yields zero.
module sbox_cf_inverter
    import sbox_cf_pkg::*;
(
    input  cf_t a,
    output cf_t q
);
    nib_t b_sq, c_sq, b_sq_l, bc, delta, delta_inv, b_xor_c;

    sbox_cf_gf4_sq  u_sq_b  (.a(a.hi), .q(b_sq));
    sbox_cf_gf4_sq  u_sq_c  (.a(a.lo), .q(c_sq));
    sbox_cf_gf4_mul u_mul_l (.a(b_sq), .b(LAMBDA), .p(b_sq_l));
    sbox_cf_gf4_mul u_mul_bc(.a(a.hi), .b(a.lo), .p(bc));

    // norm of the pair and the sum of its halves
    assign delta   = b_sq_l ^ bc ^ c_sq;
    assign b_xor_c = a.hi ^ a.lo;

    sbox_cf_gf4_inv u_inv   (.a(delta), .q(delta_inv));
    sbox_cf_gf4_mul u_mul_h (.a(a.hi), .b(delta_inv), .p(q.hi));
    sbox_cf_gf4_mul u_mul_o (.a(b_xor_c), .b(delta_inv), .p(q.lo));
endmodule

// File: rtl/sbox_cf_affine.sv
// sbox_cf_affine: AES affine bit transform (INVERSE=0) or its inverse (INVERSE=1).
// Assumes: bit 0 is the least significant bit, rotations are modulo the byte width.
module sbox_cf_affine
    import sbox_cf_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  byte_t a,
    output byte_t q
);
    if (INVERSE) begin : g_inv
        // taps at +2, +5, +7 plus constant 05h
        for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
            assign q[j] = a[(j+2)%BYTE_W] ^ a[(j+5)%BYTE_W] ^ a[(j+7)%BYTE_W] ^ INV_AFF_C[j];
        end
    end else begin : g_fwd
        // taps at +0, +4..+7 plus constant 63h
        for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
            assign q[j] = a[j] ^ a[(j+4)%BYTE_W] ^ a[(j+5)%BYTE_W]
                        ^ a[(j+6)%BYTE_W] ^ a[(j+7)%BYTE_W] ^ FWD_AFF_C[j];
        end
    end
endmodule

// File: rtl/cf_sbox.sv
// cf_sbox: combinational AES byte substitution, forward or inverse, using
// composite-field inversion instead of a full table.
// Assumes: inv_mode = 0 forward, 1 inverse; no clock, output settles same cycle.
module cf_sbox (
    input  logic [7:0] din,
    input  logic       inv_mode,
    output logic [7:0] dout
);
    import sbox_cf_pkg::*;

    byte_t pre_aff, field_in, cf_in, cf_out, field_inv, post_aff;

    sbox_cf_affine #(.INVERSE(1'b1)) u_aff_in (.a(din), .q(pre_aff));

    // inverse direction undoes the affine step before inversion
    assign field_in = inv_mode ? pre_aff : din;

    sbox_cf_basis_map #(.TO_COMPOSITE(1'b1)) u_map_in  (.a(field_in), .q(cf_in));
    sbox_cf_inverter                         u_inverter(.a(cf_t'(cf_in)), .q(cf_out));
    sbox_cf_basis_map #(.TO_COMPOSITE(1'b0)) u_map_out (.a(cf_out), .q(field_inv));

    sbox_cf_affine #(.INVERSE(1'b0)) u_aff_out (.a(field_inv), .q(post_aff));

    // forward direction applies the affine step after inversion
    assign dout = inv_mode ? field_inv : post_aff;
endmodule

// File: rtl/cf_sbox_chk.sv
// cf_sbox_chk: assertion checker for cf_sbox, bound to every instance.
// Assumes: combinational target, so checks are immediate and re-run on any change.
module cf_sbox_chk (
    input logic [7:0] din,
    input logic       inv_mode,
    input logic [7:0] dout,
    input logic [7:0] field_in,
    input logic [7:0] field_inv
);
    // plain shift-and-add product modulo 11Bh
    function automatic logic [7:0] mul8(logic [7:0] a, logic [7:0] b);
        logic [7:0] r;
        logic [7:0] s;
        r = '0;
        s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= s;
            s = s[7] ? ((s << 1) ^ 8'h1B) : (s << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] unaff(logic [7:0] x);
        logic [7:0] y;
        for (int i = 0; i < 8; i++)
            y[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8];
        return y ^ 8'h05;
    endfunction

    // checks on every input or output change
    always_comb begin
        if (!inv_mode && din == 8'h00)
            AST_FWD_ZERO: assert (dout == 8'h63) else $error("fwd zero");          // R3
        if (inv_mode && din == 8'h63)
            AST_INV_ZERO: assert (dout == 8'h00) else $error("inv zero");          // R4
        if (!inv_mode && din != 8'h00)
            AST_FWD_RECIP: assert (mul8(din, unaff(dout)) == 8'h01) else $error("fwd recip"); // R5
        if (inv_mode && din != 8'h63)
            AST_INV_RECIP: assert (mul8(dout, unaff(din)) == 8'h01) else $error("inv recip"); // R6
        if (field_in != 8'h00)
            AST_CORE_RECIP: assert (mul8(field_in, field_inv) == 8'h01) else $error("core recip"); // R5
    end
endmodule

bind cf_sbox cf_sbox_chk i_chk (
    .din      (din),
    .inv_mode (inv_mode),
    .dout     (dout),
    .field_in (field_in),
    .field_inv(field_inv)
);

// File: tb/test_cf_sbox.sv
// test_cf_sbox: scoreboard bench. Driver pushes expected bytes at posedge,
// monitor pops and compares at negedge.
module test_cf_sbox;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       inv_mode = 1'b0;
    logic [7:0] dout;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [7:0] d;
        logic       m;
        logic [7:0] expv;
        string      tag;
        int         kind;   // 0 plain, 1 fwd sweep, 2 inv sweep
    } item_t;

    item_t      sb [$];
    logic [7:0] ref_s  [256];
    logic [7:0] ref_is [256];
    bit         seen_f [256];
    bit         seen_i [256];

    cf_sbox i_cf_sbox (.din(din), .inv_mode(inv_mode), .dout(dout));

    // free-running clock
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
        for (int k = 15; k >= 8; k--) if (p[k]) p ^= 16'h11B << (k - 8);
        return p[7:0];
    endfunction

    function automatic logic [7:0] rotl(logic [7:0] x, int n);
        return (x << n) | (x >> (8 - n));
    endfunction

    function automatic logic [7:0] inv_aff(logic [7:0] x);
        return rotl(x, 1) ^ rotl(x, 3) ^ rotl(x, 6) ^ 8'h05;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic drive(logic [7:0] d, logic m, logic [7:0] expv, string tag, int kind);
        item_t it;
        @(posedge clk);
        din      <= d;
        inv_mode <= m;
        it.d = d; it.m = m; it.expv = expv; it.tag = tag; it.kind = kind;
        sb.push_back(it);
    endtask

    // monitor: compares each pending item away from the active edge
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, dout, it.expv);
            if (it.kind == 1) begin
                seen_f[dout] = 1'b1;
                if (it.d != 8'h00) check("R5 fwd reciprocal", gmul(it.d, inv_aff(dout)), 8'h01);
            end
            if (it.kind == 2) begin
                seen_i[dout] = 1'b1;
                if (it.d != 8'h63) check("R6 inv reciprocal", gmul(dout, inv_aff(it.d)), 8'h01);
            end
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // reference tables from the field definition
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv;
            iv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (x != 0 && gmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            ref_s[x] = iv ^ rotl(iv, 1) ^ rotl(iv, 2) ^ rotl(iv, 3) ^ rotl(iv, 4) ^ 8'h63;
        end
        for (int x = 0; x < 256; x++) ref_is[ref_s[x]] = 8'(x);

        // reset state: zero in, forward mode
        repeat (3) @(negedge clk);
        check("R3 reset-state", dout, 8'h63);

        // R8: output follows input with no clock edge
        din = 8'h53;
        #1;
        check("R8 no-clock response", dout, 8'hED);
        din = 8'h00;
        rst_n = 1'b1;

        // anchors and corner values
        drive(8'h01, 1'b0, 8'h7C, "R1 anchor 01", 0);
        drive(8'h53, 1'b0, 8'hED, "R1 anchor 53", 0);
        drive(8'hFF, 1'b0, 8'h16, "R1 anchor FF", 0);
        drive(8'h00, 1'b1, 8'h52, "R2 anchor 00", 0);
        drive(8'hED, 1'b1, 8'h53, "R2 anchor ED", 0);
        drive(8'h00, 1'b0, 8'h63, "R3 zero", 0);
        drive(8'h63, 1'b1, 8'h00, "R4 zero", 0);

        // full sweeps
        for (int x = 0; x < 256; x++) drive(8'(x), 1'b0, ref_s[x], "R1 sweep", 1);
        for (int x = 0; x < 256; x++) drive(8'(x), 1'b1, ref_is[x], "R2 sweep", 2);
        for (int x = 255; x >= 0; x--) drive(ref_s[x], 1'b1, 8'(x), "R7 round trip", 0);

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);

        // R9: distinct outputs per mode
        begin
            int nf;
            int ni;
            nf = 0;
            ni = 0;
            for (int x = 0; x < 256; x++) begin
                nf += int'(seen_f[x]);
                ni += int'(seen_i[x]);
            end
            total++;
            if (nf != 256) begin
                bad++;
                $display("FAIL R9 fwd distinct: got %0d expected 256", nf);
            end
            total++;
            if (ni != 256) begin
                bad++;
                $display("FAIL R9 inv distinct: got %0d expected 256", ni);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule